// File: doc/BRIEF.md
# Windowed Configuration Access Translator

This block takes CPU loads and stores that land in a fixed 4 MiB physical window and reissues them as configuration requests on a little-endian configuration port. The slot that the access targets comes from a one-hot select field in the window offset: the position of the lowest set bit in that field is the device number. The translated address keeps the 11 low offset bits as they are and places the device number above them. On the way out, multi-byte store data is byte-swapped. On the way back, load data is swapped the same way, so a big-endian CPU sees configuration registers in its own byte order.

The CPU request channel is valid/ready. A request is taken only on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low for addresses outside the window, for unsupported size codes, and while an earlier access is still outstanding, so the CPU must hold the request until the block accepts it. The configuration request channel is also valid/ready. The block holds every field of its request stable until `cfg_req_ready` is seen high. The configuration response and the CPU response are single-cycle strobes with no back-pressure.

Separately, the block folds four interrupt pins per device slot onto two interrupt controller inputs. Each pin goes to one of the two lines, chosen by a parity rule on the pin and slot numbers. Each line is a level-sensitive OR of its pins, registered once.

Top module: `cfg_window_xlat`

## Requirements
- R1: `cpu_req_ready` is high only when the block is idle, `cpu_req_addr[31:22]` equals 10'h202 (window 0x8080_0000 to 0x80BF_FFFF), and `cpu_req_size` is 1, 2 or 4. Any other request is not accepted and issues no configuration request.
- R2: The device number is the index k (0 to 10) of the lowest set bit among offset bits 11 to 21, where bit 11+k is the one examined. If none of those bits is set, the device number is 11. `cfg_req_addr` is {device number (4 bits), offset[10:0]}.
- R3: `cfg_req_size` and `cfg_req_write` repeat the accepted request's size code and direction unchanged.
- R4: Store data goes out as follows. Size 1 sends {24'h0, wdata[7:0]}. Size 2 sends {16'h0, wdata[7:0], wdata[15:8]}. Size 4 sends the four bytes in reverse order.
- R5: Load data uses the same rule as R4, applied to `cfg_rsp_rdata`. The result appears on `cpu_rsp_rdata` together with a one-cycle `cpu_rsp_valid`, in the cycle after the edge that samples `cfg_rsp_valid`.
- R6: `cfg_req_valid` rises in the cycle after acceptance. While it is high and `cfg_req_ready` is low, the address, size, direction and data do not change. `cpu_req_ready` stays low from acceptance until the response.
- R7: A store is acknowledged by a one-cycle `cpu_rsp_valid` in the cycle after the configuration handshake edge.
- R8: Pin p (0 to 3) of slot d is bit `dev_irq[4*d+p]`. It maps to line (p+d)&1. Line 0 drives `irq_to_pic9` and line 1 drives `irq_to_pic11`.
- R9: Each interrupt output is the OR of all pins mapped to it, delayed by exactly one clock edge.
- R10: While `rst_n` is low, `cfg_req_valid`, `cpu_rsp_valid` and both interrupt outputs are low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block accepts the CPU request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | CPU physical address |
| cpu_req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| cpu_req_wdata | input | 32 | Store data, CPU byte order, right-justified |
| cpu_rsp_valid | output | 1 | One-cycle completion strobe |
| cpu_rsp_rdata | output | 32 | Load data after swapping |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration port takes the request |
| cfg_req_write | output | 1 | Configuration request direction |
| cfg_req_addr | output | 15 | {device number, register offset} |
| cfg_req_size | output | 3 | Size code forwarded from the CPU |
| cfg_req_wdata | output | 32 | Swapped store data |
| cfg_rsp_valid | input | 1 | Read data valid strobe |
| cfg_rsp_rdata | input | 32 | Read data, little-endian order |
| dev_irq | input | 48 | Four interrupt pins per slot, 12 slots |
| irq_to_pic9 | output | 1 | Folded line 0 to controller input 9 |
| irq_to_pic11 | output | 1 | Folded line 1 to controller input 11 |

## Verification
The interrupt folding and a configuration transaction can change outputs on the same edge. The two paths share no state, so each must stay correct while the other is active. The bench drives a new interrupt pattern in the cycle a CPU access is accepted, holds the configuration port busy, and then checks the folded lines against a parity sum it computes itself. In the same run it checks that the pending request fields stayed intact and that the swapped response still arrives on time. The one-hot decode and byte swap are swept over all twelve device numbers and all three sizes in both directions.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd1,
    SZ_HALF = 3'd2,
    SZ_WORD = 3'd4
  } cfgx_size_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } cfgx_state_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

  // Endian conversion across the bus boundary; symmetric, so one function
  // serves both directions.
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d,
                                                  input logic [2:0] sz);
    logic [DATA_W-1:0] r;
    case (sz)
      SZ_BYTE: r = {24'h0, d[7:0]};
      SZ_HALF: r = {16'h0, d[7:0], d[15:8]};
      default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfgx_dev_decode.sv
module cfgx_dev_decode #(
  parameter int SEL_BITS = 11,
  parameter int DEV_W    = $clog2(SEL_BITS + 1)
) (
  input  logic [SEL_BITS-1:0] sel,
  output logic [DEV_W-1:0]    dev
);

  // Lowest set bit wins; no bit set yields SEL_BITS.
  logic [DEV_W-1:0] chain [SEL_BITS+1];

  assign chain[SEL_BITS] = DEV_W'(SEL_BITS);

  for (genvar i = SEL_BITS - 1; i >= 0; i--) begin : g_prio
    assign chain[i] = sel[i] ? DEV_W'(i) : chain[i+1];
  end

  assign dev = chain[0];

endmodule

// File: rtl/cfgx_irq_fold.sv
module cfgx_irq_fold #(
  parameter int NDEV = 12,
  parameter int PINS = 4,
  localparam int NPIN = NDEV * PINS
) (
  input  logic [NPIN-1:0] pins,
  output logic [1:0]      lines
);

  logic [NPIN-1:0] even_pins;
  logic [NPIN-1:0] odd_pins;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int IDX = d * PINS + p;
      if (((d + p) % 2) == 0) begin : g_even
        assign even_pins[IDX] = pins[IDX];
        assign odd_pins[IDX]  = 1'b0;
      end else begin : g_odd
        assign even_pins[IDX] = 1'b0;
        assign odd_pins[IDX]  = pins[IDX];
      end
    end
  end

  assign lines[0] = |even_pins;
  assign lines[1] = |odd_pins;

endmodule

// File: rtl/cfgx_xact_fsm.sv
module cfgx_xact_fsm
  import cfgx_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              idle,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [AW-1:0]     cfg_req_addr,
  output logic [2:0]        cfg_req_size,
  output logic [DATA_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [DATA_W-1:0] cfg_rsp_rdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata
);

  cfgx_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= XS_IDLE;
      cfg_req_write <= 1'b0;
      cfg_req_addr  <= '0;
      cfg_req_size  <= SZ_BYTE;
      cfg_req_wdata <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (state_q)
        XS_IDLE: begin
          if (acc) begin
            cfg_req_write <= acc_write;
            cfg_req_addr  <= acc_addr;
            cfg_req_size  <= acc_size;
            cfg_req_wdata <= acc_wdata;
            state_q       <= XS_ISSUE;
          end
        end
        XS_ISSUE: begin
          if (cfg_req_ready) begin
            if (cfg_req_write) begin
              cpu_rsp_valid <= 1'b1;
              state_q       <= XS_IDLE;
            end else begin
              state_q <= XS_WAIT;
            end
          end
        end
        XS_WAIT: begin
          if (cfg_rsp_valid) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= lane_swap(cfg_rsp_rdata, cfg_req_size);
            state_q       <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign idle          = (state_q == XS_IDLE);
  assign cfg_req_valid = (state_q == XS_ISSUE);

endmodule

// File: rtl/cfg_window_xlat.sv
module cfg_window_xlat
  import cfgx_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_LOG2 = 22,
  parameter int SEL_LSB  = 11,
  parameter int SEL_BITS = 11,
  parameter int NDEV     = 12,
  parameter int PINS     = 4,
  localparam int DEV_W   = $clog2(SEL_BITS + 1),
  localparam int CFG_AW  = SEL_LSB + DEV_W,
  localparam int NPIN    = NDEV * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [31:0]       cpu_req_addr,
  input  logic [2:0]        cpu_req_size,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [CFG_AW-1:0] cfg_req_addr,
  output logic [2:0]        cfg_req_size,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [31:0]       cfg_rsp_rdata,
  input  logic [NPIN-1:0]   dev_irq,
  output logic              irq_to_pic9,
  output logic              irq_to_pic11
);

  logic [WIN_LOG2-1:0] win_off;
  logic                win_hit;
  logic                xact_idle;
  logic                accept;
  logic [DEV_W-1:0]    dev_num;
  logic [CFG_AW-1:0]   xl_addr;
  logic [1:0]          fold_lines;

  assign win_off = cpu_req_addr[WIN_LOG2-1:0];
  assign win_hit = (cpu_req_addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);

  assign cpu_req_ready = xact_idle && win_hit && size_legal(cpu_req_size);
  assign accept        = cpu_req_valid && cpu_req_ready;

  cfgx_dev_decode #(
    .SEL_BITS (SEL_BITS),
    .DEV_W    (DEV_W)
  ) u_decode (
    .sel (win_off[SEL_LSB +: SEL_BITS]),
    .dev (dev_num)
  );

  assign xl_addr = {dev_num, win_off[SEL_LSB-1:0]};

  cfgx_xact_fsm #(
    .AW (CFG_AW)
  ) u_xact (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (accept),
    .acc_write     (cpu_req_write),
    .acc_addr      (xl_addr),
    .acc_size      (cpu_req_size),
    .acc_wdata     (lane_swap(cpu_req_wdata, cpu_req_size)),
    .idle          (xact_idle),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_write (cfg_req_write),
    .cfg_req_addr  (cfg_req_addr),
    .cfg_req_size  (cfg_req_size),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_rdata (cfg_rsp_rdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata)
  );

  cfgx_irq_fold #(
    .NDEV (NDEV),
    .PINS (PINS)
  ) u_fold (
    .pins  (dev_irq),
    .lines (fold_lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_to_pic9  <= 1'b0;
      irq_to_pic11 <= 1'b0;
    end else begin
      irq_to_pic9  <= fold_lines[0];
      irq_to_pic11 <= fold_lines[1];
    end
  end

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_LOG2 = 22,
  parameter int CFG_AW   = 15,
  parameter int NPIN     = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic [31:0]       cpu_req_addr,
  input logic              cpu_rsp_valid,
  input logic              cfg_req_valid,
  input logic              cfg_req_ready,
  input logic              cfg_req_write,
  input logic [CFG_AW-1:0] cfg_req_addr,
  input logic [2:0]        cfg_req_size,
  input logic [31:0]       cfg_req_wdata,
  input logic [NPIN-1:0]   dev_irq,
  input logic              irq_to_pic9,
  input logic              irq_to_pic11
);

  assert_outside_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_addr[31:WIN_LOG2] != WIN_BASE[31:WIN_LOG2]) |-> !cpu_req_ready);

  assert_size_forwarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_size == 3'd1 || cfg_req_size == 3'd2 || cfg_req_size == 3'd4));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid && $stable(cfg_req_addr)
      && $stable(cfg_req_size) && $stable(cfg_req_write) && $stable(cfg_req_wdata)));

  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !cpu_req_ready);

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_irq) == '0) |-> (!irq_to_pic9 && !irq_to_pic11));

endmodule

bind cfg_window_xlat cfgx_checker #(
  .WIN_BASE (WIN_BASE),
  .WIN_LOG2 (WIN_LOG2),
  .CFG_AW   (CFG_AW),
  .NPIN     (NPIN)
) u_cfgx_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_addr  (cfg_req_addr),
  .cfg_req_size  (cfg_req_size),
  .cfg_req_wdata (cfg_req_wdata),
  .dev_irq       (dev_irq),
  .irq_to_pic9   (irq_to_pic9),
  .irq_to_pic11  (irq_to_pic11)
);

// File: tb/cfg_window_xlat_bench.sv
`timescale 1ns/1ps
module cfg_window_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [2:0]  cpu_req_size = 3'd1;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        cfg_req_valid;
  logic        cfg_req_ready = 1'b0;
  logic        cfg_req_write;
  logic [14:0] cfg_req_addr;
  logic [2:0]  cfg_req_size;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [47:0] dev_irq = '0;
  logic        irq_to_pic9;
  logic        irq_to_pic11;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_window_xlat u_cfg_window_xlat (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_addr(cfg_req_addr),
    .cfg_req_size(cfg_req_size), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
    .dev_irq(dev_irq), .irq_to_pic9(irq_to_pic9), .irq_to_pic11(irq_to_pic11)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] swap_model(input logic [31:0] d, input int sz);
    if (sz == 1) return d & 32'hFF;
    if (sz == 2) return ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
    return ((d & 32'hFF) << 24) | (((d >> 8) & 32'hFF) << 16)
         | (((d >> 16) & 32'hFF) << 8) | ((d >> 24) & 32'hFF);
  endfunction

  function automatic logic [1:0] fold_model(input logic [47:0] v);
    logic [1:0] r = 2'b00;
    for (int d = 0; d < 12; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p]) r[(d+p)%2] = 1'b1;
    return r;
  endfunction

  // One full access; irq_pat is applied in the accept cycle (R8/R9 concurrency).
  task automatic do_access(input bit wr, input logic [31:0] addr, input int sz,
                           input logic [31:0] wd, input logic [31:0] rd_cfg,
                           input logic [14:0] exp_addr, input int rdy_dly,
                           input int rsp_dly, input logic [47:0] irq_pat);
    logic [1:0] fexp;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr;
    cpu_req_size = 3'(sz); cpu_req_wdata = wd; dev_irq = irq_pat;
    #1;
    chk(cpu_req_ready == 1'b1, "R1 ready in window", 32'(cpu_req_ready), 1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(cfg_req_valid == 1'b1, "R6 cfg valid after accept", 32'(cfg_req_valid), 1);
    chk(cfg_req_addr == exp_addr, "R2 translated address", 32'(cfg_req_addr), 32'(exp_addr));
    chk(cfg_req_size == 3'(sz) && cfg_req_write == wr, "R3 size/dir forwarded",
        {28'h0, cfg_req_write, cfg_req_size}, {28'h0, wr, 3'(sz)});
    if (wr) chk(cfg_req_wdata == swap_model(wd, sz), "R4 write swap",
                cfg_req_wdata, swap_model(wd, sz));
    fexp = fold_model(irq_pat);
    chk({irq_to_pic11, irq_to_pic9} == fexp, "R8 irq alongside access",
        32'({irq_to_pic11, irq_to_pic9}), 32'(fexp));
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk(cfg_req_valid && cfg_req_addr == exp_addr && !cpu_req_ready,
          "R6 hold under back-pressure", 32'(cfg_req_addr), 32'(exp_addr));
    end
    cfg_req_ready = 1'b1;
    @(negedge clk);
    cfg_req_ready = 1'b0;
    if (wr) begin
      chk(cpu_rsp_valid == 1'b1, "R7 write ack", 32'(cpu_rsp_valid), 1);
    end else begin
      chk(cpu_rsp_valid == 1'b0 && cfg_req_valid == 1'b0, "R5 no early ack",
          32'(cpu_rsp_valid), 0);
      for (int i = 0; i < rsp_dly; i++) begin
        @(negedge clk);
        chk(cpu_rsp_valid == 1'b0 && !cpu_req_ready, "R5 stalled read",
            32'(cpu_rsp_valid), 0);
      end
      cfg_rsp_valid = 1'b1; cfg_rsp_rdata = rd_cfg;
      @(negedge clk);
      cfg_rsp_valid = 1'b0; cfg_rsp_rdata = 32'hDEAD_BEEF;
      chk(cpu_rsp_valid == 1'b1, "R5 read ack", 32'(cpu_rsp_valid), 1);
      chk(cpu_rsp_rdata == swap_model(rd_cfg, sz), "R5 read swap",
          cpu_rsp_rdata, swap_model(rd_cfg, sz));
    end
    @(negedge clk);
    chk(cpu_rsp_valid == 1'b0, "R5 ack one cycle", 32'(cpu_rsp_valid), 0);
  endtask

  initial begin
    logic [31:0] a;
    logic [1:0]  prev;
    logic [47:0] pat;
    int          sizes [3] = '{1, 2, 4};

    // R10: reset state with busy inputs
    dev_irq = '1; cpu_req_valid = 1'b1; cpu_req_addr = 32'h8080_0000;
    repeat (3) @(negedge clk);
    chk(!cfg_req_valid && !cpu_rsp_valid, "R10 no request in reset",
        {30'h0, cfg_req_valid, cpu_rsp_valid}, 0);
    chk(!irq_to_pic9 && !irq_to_pic11, "R10 irq low in reset",
        {30'h0, irq_to_pic11, irq_to_pic9}, 0);
    dev_irq = '0; cpu_req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outside window and illegal sizes are not claimed
    for (int t = 0; t < 5; t++) begin
      cpu_req_valid = 1'b1; cpu_req_size = 3'd4;
      case (t)
        0: cpu_req_addr = 32'h807F_FFFC;
        1: cpu_req_addr = 32'h80C0_0000;
        2: cpu_req_addr = 32'h0080_0000;
        3: begin cpu_req_addr = 32'h8080_0800; cpu_req_size = 3'd3; end
        default: begin cpu_req_addr = 32'h8080_0800; cpu_req_size = 3'd0; end
      endcase
      #1;
      chk(cpu_req_ready == 1'b0, "R1 not claimed", 32'(cpu_req_ready), 0);
      @(negedge clk);
      chk(cfg_req_valid == 1'b0, "R1 no cfg request", 32'(cfg_req_valid), 0);
    end
    cpu_req_valid = 1'b0;

    // R2-R7: sweep device numbers, sizes, directions
    for (int k = 0; k < 12; k++) begin
      for (int si = 0; si < 3; si++) begin
        for (int w = 0; w < 2; w++) begin
          logic [10:0] low;
          logic [14:0] ea;
          low = 11'((k * 37 + si * 101 + 5) & 32'h7FF);
          a = 32'h8080_0000 | 32'(low);
          if (k < 11) a = a | (32'h1 << (11 + k));
          if (k < 10) a = a | (32'h1 << 21);
          if (k < 9)  a = a | (32'h1 << (13 + k));
          ea = {4'(k), low};
          pat = '0;
          pat[(k * 4 + si + w) % 48] = 1'b1;
          do_access(w[0], a, sizes[si], 32'hA1B2_C3D4 ^ 32'(k * 257 + si),
                    32'h1122_3344 + 32'(k * 16 + si), ea, (k + w) % 3, si % 3, pat);
        end
      end
    end
    dev_irq = '0;
    @(negedge clk);

    // R8/R9: every single pin, one-edge latency
    prev = 2'b00;
    for (int d = 0; d < 12; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [1:0] e;
        @(negedge clk);
        pat = '0; pat[d*4+p] = 1'b1;
        dev_irq = pat;
        #1;
        chk({irq_to_pic11, irq_to_pic9} == prev, "R9 registered once",
            32'({irq_to_pic11, irq_to_pic9}), 32'(prev));
        @(negedge clk);
        e = (((d + p) % 2) == 0) ? 2'b01 : 2'b10;
        chk({irq_to_pic11, irq_to_pic9} == e, "R8 pin to line",
            32'({irq_to_pic11, irq_to_pic9}), 32'(e));
        prev = e;
      end
    end

    // R9: OR over several pins
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      case (t)
        0: pat = 48'h0000_0000_0005;
        1: pat = 48'h0000_0000_0012;
        2: pat = 48'hA000_0000_0100;
        default: pat = '0;
      endcase
      dev_irq = pat;
      @(negedge clk);
      chk({irq_to_pic11, irq_to_pic9} == fold_model(pat), "R9 level OR",
          32'({irq_to_pic11, irq_to_pic9}), 32'(fold_model(pat)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule